// File: doc/BRIEF.md
# Precise Fault Commit and Trap Unit

This block sits at the retire end of an out-of-order core and turns a recorded execution outcome into a precise machine trap. Each reorder-list entry carries a three-bit execution-state code written at writeback. The unit looks only at the oldest entry. While that entry reports a clean completion, the unit grants retirement. When the entry reports a fault or an environment call, the unit withholds retirement and starts a fixed trap sequence. It does not try to recover from the fault.

The trap sequence has three steps. In the first cycle the unit captures the cause, the PC and the trap value. In the next cycle it raises a flush that discards every in-flight instruction, including the one that faulted, and commits the exception PC, trap value and cause registers. In the cycle after that it issues a one-cycle fetch redirect to the direct-mode trap vector. An external interrupt request is sampled at the same decision point and wins over a fault in the same cycle. It records the oldest instruction's PC as the return address, so that instruction executes again later.

Top module: `trap_commit_unit`

## Requirements
- R1: After reset, mepc, mtval and mcause read zero, and commitEn, flushReq and redirectValid are low while no head entry is valid.
- R2: When the unit is idle, the head is valid with state 0 (success) and no interrupt is requested, commitEn is high in that same cycle.
- R3: A valid head with state 1..5 and no interrupt request, seen while idle, holds commitEn low in that cycle. flushReq is then high for exactly the following cycle.
- R4: redirectValid is high for exactly the cycle after the flush cycle. In that cycle redirectPc equals trapVector with its two low bits cleared. At all other times redirectPc is zero.
- R5: From the redirect cycle onward after a fault trap, mepc holds the head PC and the mcause interrupt bit (bit XLEN-1) is 0. mtval holds the head data address for states 2..5, and zero for state 1.
- R6: The mcause code field (low five bits) follows a fixed map: state 1 (environment call) gives 11, state 2 (load misaligned) gives 4, state 3 (load access) gives 5, state 4 (store misaligned) gives 6, and state 5 (store access) gives 7.
- R7: An interrupt request seen while idle with a valid head takes a trap. mcause then has bit XLEN-1 set and irqCode in its low five bits, mepc holds the head PC, and mtval is zero.
- R8: When an interrupt request and a faulting head arrive in the same cycle, the interrupt is taken. If the fault is still at the head afterwards, it is trapped by a later, separate sequence.
- R9: commitEn is low during the flush and redirect cycles. Head contents and interrupt requests in those cycles start no new trap.
- R10: Head states 6 and 7 (not yet completed) and an invalid head cause neither retirement nor a fault trap. With no valid head, an interrupt request is not taken.
- R11: mepc, mtval and mcause change only on the edge that ends a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | 1 | Oldest reorder-list entry is present |
| headState | input | 3 | Execution-state code of the oldest entry |
| headPc | input | XLEN | PC of the oldest entry |
| headAddr | input | XLEN | Data address of the oldest entry |
| irqReq | input | 1 | External interrupt request |
| irqCode | input | 5 | Cause code for the interrupt |
| trapVector | input | XLEN | Trap vector register value, direct mode |
| commitEn | output | 1 | Oldest entry may retire this cycle |
| flushReq | output | 1 | Discard all in-flight instructions |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | XLEN | Trap handler address |
| mepc | output | XLEN | Exception PC register |
| mtval | output | XLEN | Trap value register |
| mcause | output | XLEN | Cause register, interrupt flag in the top bit |

## Verification
Two events can fall in the same cycle: a faulting entry reaching the head, and an external interrupt request. A directed case presents a load access fault together with an interrupt. The check is that the recorded cause carries the interrupt flag and the interrupt code. After the redirect the same fault is left at the head, and a second, separate trap must record code 5 with the interrupt flag clear. Random stimulus raises interrupts against random head states often enough that the two also meet many more times. Each of those cycles is judged against a cycle-level bench model.

// File: rtl/trap_commit_pkg.sv
package trap_commit_pkg;

  localparam int STATE_W = 3;
  localparam int CODE_W  = 5;

  typedef enum logic [STATE_W-1:0] {
    EX_OK        = 3'd0,
    EX_ENVCALL   = 3'd1,
    EX_LD_MISAL  = 3'd2,
    EX_LD_ACCESS = 3'd3,
    EX_ST_MISAL  = 3'd4,
    EX_ST_ACCESS = 3'd5,
    EX_RSVD      = 3'd6,
    EX_BUSY      = 3'd7
  } exec_state_e;

  typedef enum logic [1:0] {
    PH_RUN      = 2'd0,
    PH_FLUSH    = 2'd1,
    PH_REDIRECT = 2'd2
  } trap_phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // latch head info for a pending trap
    logic takeIrq;   // the pending trap is an interrupt
    logic csrWrite;  // commit pending info into the CSRs
    logic flush;     // pipeline flush cycle
    logic redirect;  // fetch redirect cycle
    logic commit;    // head may retire
  } trap_strobe_t;

  function automatic logic isFaultState(exec_state_e s);
    return (s == EX_ENVCALL) || (s == EX_LD_MISAL) || (s == EX_LD_ACCESS) ||
           (s == EX_ST_MISAL) || (s == EX_ST_ACCESS);
  endfunction

  function automatic logic carriesDataAddr(exec_state_e s);
    return (s == EX_LD_MISAL) || (s == EX_LD_ACCESS) ||
           (s == EX_ST_MISAL) || (s == EX_ST_ACCESS);
  endfunction

  function automatic logic [CODE_W-1:0] causeCodeOf(exec_state_e s);
    logic [CODE_W-1:0] c;
    case (s)
      EX_ENVCALL:   c = 5'd11;
      EX_LD_MISAL:  c = 5'd4;
      EX_LD_ACCESS: c = 5'd5;
      EX_ST_MISAL:  c = 5'd6;
      EX_ST_ACCESS: c = 5'd7;
      default:      c = 5'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/trap_commit_ctrl.sv
module trap_commit_ctrl
  import trap_commit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         headValid,
  input  exec_state_e  headState,
  input  logic         irqReq,
  output trap_strobe_t strb
);

  trap_phase_e phase, phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    case (phase)
      PH_RUN: begin
        if (headValid && irqReq) begin
          // interrupt outranks a fault at the head
          strb.capture = 1'b1;
          strb.takeIrq = 1'b1;
          phaseNext    = PH_FLUSH;
        end else if (headValid && isFaultState(headState)) begin
          strb.capture = 1'b1;
          phaseNext    = PH_FLUSH;
        end else begin
          strb.commit = headValid && (headState == EX_OK);
        end
      end
      PH_FLUSH: begin
        strb.flush    = 1'b1;
        strb.csrWrite = 1'b1;
        phaseNext     = PH_REDIRECT;
      end
      PH_REDIRECT: begin
        strb.redirect = 1'b1;
        phaseNext     = PH_RUN;
      end
      default: phaseNext = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_RUN;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/trap_commit_datapath.sv
module trap_commit_datapath
  import trap_commit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trap_strobe_t      strb,
  input  exec_state_e       headState,
  input  logic [XLEN-1:0]   headPc,
  input  logic [XLEN-1:0]   headAddr,
  input  logic [CODE_W-1:0] irqCode,
  input  logic [XLEN-1:0]   trapVector,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   redirectPc
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [XLEN-1:0]   pendPc, pendTval;
  logic              pendIrq;
  logic [CODE_W-1:0] pendCode;
  logic [XLEN-1:0]   causeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPc   <= '0;
      pendTval <= '0;
      pendIrq  <= 1'b0;
      pendCode <= '0;
    end else if (strb.capture) begin
      pendPc   <= headPc;
      pendIrq  <= strb.takeIrq;
      pendCode <= strb.takeIrq ? irqCode : causeCodeOf(headState);
      pendTval <= (!strb.takeIrq && carriesDataAddr(headState)) ? headAddr : '0;
    end
  end

  assign causeWord = {pendIrq, {PAD_W{1'b0}}, pendCode};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mepc   <= '0;
      mtval  <= '0;
      mcause <= '0;
    end else if (strb.csrWrite) begin
      mepc   <= pendPc;
      mtval  <= pendTval;
      mcause <= causeWord;
    end
  end

  // direct mode: mode bits of the vector are dropped
  assign redirectPc = strb.redirect ? {trapVector[XLEN-1:2], 2'b00} : '0;

endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
  import trap_commit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headValid,
  input  logic [2:0]        headState,
  input  logic [XLEN-1:0]   headPc,
  input  logic [XLEN-1:0]   headAddr,
  input  logic              irqReq,
  input  logic [4:0]        irqCode,
  input  logic [XLEN-1:0]   trapVector,
  output logic              commitEn,
  output logic              flushReq,
  output logic              redirectValid,
  output logic [XLEN-1:0]   redirectPc,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   mcause
);

  trap_strobe_t strb;
  exec_state_e  stateTyped;

  assign stateTyped = exec_state_e'(headState);

  trap_commit_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .headValid (headValid),
    .headState (stateTyped),
    .irqReq    (irqReq),
    .strb      (strb)
  );

  trap_commit_datapath #(.XLEN(XLEN)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .headState  (stateTyped),
    .headPc     (headPc),
    .headAddr   (headAddr),
    .irqCode    (irqCode),
    .trapVector (trapVector),
    .mepc       (mepc),
    .mtval      (mtval),
    .mcause     (mcause),
    .redirectPc (redirectPc)
  );

  assign commitEn      = strb.commit;
  assign flushReq      = strb.flush;
  assign redirectValid = strb.redirect;

endmodule

// File: rtl/trap_commit_checker.sv
module trap_commit_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            headValid,
  input logic [2:0]      headState,
  input logic            irqReq,
  input logic [XLEN-1:0] trapVector,
  input logic            commitEn,
  input logic            flushReq,
  input logic            redirectValid,
  input logic [XLEN-1:0] redirectPc,
  input logic [XLEN-1:0] mepc,
  input logic [XLEN-1:0] mtval,
  input logic [XLEN-1:0] mcause
);

  // R2 / R10: retirement only for a clean, completed head with no interrupt
  assert_commit_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> (headValid && headState == 3'd0 && !irqReq));

  // R3: flush lasts one cycle and is followed by the redirect
  assert_flush_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (!flushReq && redirectValid));

  // R4: redirect target is the aligned vector
  assert_redirect_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectPc == {trapVector[XLEN-1:2], 2'b00}));

  // R9: no retirement while a trap sequence runs
  assert_no_commit_in_trap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq || redirectValid) |-> !commitEn);

  // R11: CSRs move only after a flush cycle
  assert_csr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flushReq) |-> ($stable(mepc) && $stable(mtval) && $stable(mcause)));

  // R7: an interrupt trap leaves a zero trap value
  assert_irq_tval_R7: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && mcause[XLEN-1]) |-> (mtval == '0));

endmodule

bind trap_commit_unit trap_commit_checker #(.XLEN(XLEN)) uChecker (
  .clk           (clk),
  .rstN          (rstN),
  .headValid     (headValid),
  .headState     (headState),
  .irqReq        (irqReq),
  .trapVector    (trapVector),
  .commitEn      (commitEn),
  .flushReq      (flushReq),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .mepc          (mepc),
  .mtval         (mtval),
  .mcause        (mcause)
);

// File: tb/trap_commit_unit_test.sv
`timescale 1ns/1ps
module trap_commit_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        headValid;
  logic [2:0]  headState;
  logic [31:0] headPc, headAddr;
  logic        irqReq;
  logic [4:0]  irqCode;
  logic [31:0] trapVector;
  logic        commitEn, flushReq, redirectValid;
  logic [31:0] redirectPc, mepc, mtval, mcause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  int          mPhase = 0;
  logic [31:0] mPendPc, mPendTval, mPendCause;
  logic [31:0] mMepc = 0, mMtval = 0, mMcause = 0;

  always #2.5 clk = ~clk;

  trap_commit_unit #(.XLEN(32)) uut (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headState(headState),
    .headPc(headPc), .headAddr(headAddr), .irqReq(irqReq), .irqCode(irqCode),
    .trapVector(trapVector), .commitEn(commitEn), .flushReq(flushReq),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .mepc(mepc),
    .mtval(mtval), .mcause(mcause)
  );

  function automatic logic [4:0] expCode(input logic [2:0] s);
    case (s)
      3'd1: return 5'd11;
      3'd2: return 5'd4;
      3'd3: return 5'd5;
      3'd4: return 5'd6;
      3'd5: return 5'd7;
      default: return 5'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic hv, input logic [2:0] st, input logic [31:0] pc,
                      input logic [31:0] ad, input logic ir, input logic [4:0] ic);
    logic expCommit;
    string tc, tcsr;
    @(negedge clk);
    headValid = hv; headState = st; headPc = pc; headAddr = ad;
    irqReq = ir; irqCode = ic;
    #1;
    expCommit = (mPhase == 0) && hv && !ir && (st == 3'd0);
    tc = (mPhase != 0) ? "R9" : ((!hv || st >= 3'd6) ? "R10" : "R2");
    chk(commitEn == expCommit, tc, commitEn, expCommit);
    chk(flushReq == (mPhase == 1), "R3", flushReq, mPhase == 1);
    chk(redirectValid == (mPhase == 2), "R4", redirectValid, mPhase == 2);
    chk(redirectPc == ((mPhase == 2) ? (trapVector & ~32'h3) : 32'h0), "R4",
        redirectPc, (mPhase == 2) ? (trapVector & ~32'h3) : 32'h0);
    tcsr = (mPhase == 2) ? (mMcause[31] ? "R7" : "R5") : "R11";
    chk(mepc == mMepc, tcsr, mepc, mMepc);
    chk(mtval == mMtval, tcsr, mtval, mMtval);
    chk(mcause == mMcause, (mPhase == 2 && !mMcause[31]) ? "R6" : tcsr, mcause, mMcause);
    // advance model across the coming edge
    case (mPhase)
      0: begin
        if (hv && ir) begin
          mPendPc = pc; mPendTval = 0; mPendCause = {1'b1, 26'b0, ic}; mPhase = 1;
        end else if (hv && st >= 3'd1 && st <= 3'd5) begin
          mPendPc = pc;
          mPendTval = (st == 3'd1) ? 32'h0 : ad;
          mPendCause = {27'b0, expCode(st)};
          mPhase = 1;
        end
      end
      1: begin
        mMepc = mPendPc; mMtval = mPendTval; mMcause = mPendCause; mPhase = 2;
      end
      default: mPhase = 0;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = 32'h5eed;
    r = $urandom(seed);
    rstN = 1'b0; headValid = 0; headState = 0; headPc = 0; headAddr = 0;
    irqReq = 0; irqCode = 0; trapVector = 32'h0000_1A03;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    chk(mepc == 0 && mtval == 0 && mcause == 0, "R1", {mepc, mcause}, 0);
    chk(!commitEn && !flushReq && !redirectValid, "R1",
        {commitEn, flushReq, redirectValid}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // directed: clean retire, then each fault kind (R2, R3, R5, R6)
    step(1, 0, 32'h100, 32'h0, 0, 0);
    for (int k = 1; k <= 5; k++) begin
      step(1, 3'(k), 32'h200 + 32'(k) * 4, 32'hA000_0000 + 32'(k), 0, 0);
      step(1, 0, 32'h300, 32'h0, 1, 5'd3);   // flush cycle, irq ignored (R9)
      step(1, 3'(k), 32'h304, 32'h0, 0, 0); // redirect cycle, fault ignored (R9)
      chk(mcause[4:0] == expCode(3'(k)), "R6", mcause[4:0], expCode(3'(k)));
    end

    // R10: busy/reserved states and invalid head with interrupt
    step(1, 7, 32'h400, 0, 0, 0);
    step(1, 6, 32'h404, 0, 0, 0);
    step(0, 3, 32'h408, 0, 1, 5'd7);
    step(1, 0, 32'h40C, 0, 0, 0);
    chk(flushReq == 0, "R10", flushReq, 0);

    // R8: interrupt and fault in the same cycle
    step(1, 3, 32'h500, 32'hBEEF_0000, 1, 5'd7);
    step(1, 3, 32'h500, 32'hBEEF_0000, 0, 0);
    step(1, 3, 32'h500, 32'hBEEF_0000, 0, 0);
    chk(mcause == 32'h8000_0007 && mepc == 32'h500, "R8", mcause, 32'h8000_0007);
    chk(mtval == 0, "R7", mtval, 0);
    step(1, 3, 32'h500, 32'hBEEF_0000, 0, 0);   // fault taken now
    step(1, 0, 32'h0, 32'h0, 0, 0);
    step(1, 0, 32'h0, 32'h0, 0, 0);
    chk(mcause == 32'h5 && mtval == 32'hBEEF_0000, "R8", mcause, 32'h5);

    // random phase
    trapVector = 32'h8000_0101;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b, c;
      logic [2:0] st;
      a = $urandom; b = $urandom; c = $urandom;
      st = (a[3:0] < 4'd9) ? 3'd0 : a[6:4];
      step(a[12:10] != 3'd0, st, b & ~32'h3, c, a[20:18] == 3'd0, a[28:24]);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule